// File: doc/BRIEF.md
# Multiplexed Byte-Bus Host Interface

This block is the host-side front end of a small peripheral that offers one shared 8-bit bus for both addresses and data. A select line tells the block whether the current transfer carries an address or a data byte. An address transfer loads the register pointer. Later data transfers read or write the register the pointer selects. The pointer keeps its value until the next address transfer, so several data transfers can follow one address.

The pointer selects either a 16-byte user RAM inside this block or a register in the neighbouring core, which is reached through a simple pointer/write-pulse/read-data port. Two strobe styles share the same pins, and a static strap input picks between them:
- **Separate-strobe style:** a read strobe and a write strobe.
- **Data-strobe style:** one data strobe plus a direction level.

While the power-fail input is high, the block accepts no access and does not drive the bus. There is no wait or busy handshake. Every pin is sampled on the block clock, and all timing is at cycle granularity.

Top module: `mux_bus_if`

## Requirements
- R1: After reset, bus_oe and core_we are 0 and core_addr is 0x00.
- R2: A write transfer with ad_sel=1 (address) loads the byte on bus_in into the pointer when the transfer commits. core_addr shows the new value from the cycle after the commit edge.
- R3: In separate-strobe mode (style_ds=0), strb_n is the active-low read strobe and dir_pin is the active-low write strobe. A read runs while cs_n=0, strb_n=0 and dir_pin=1. One cycle after the first clock edge that samples the read active with ad_sel=0, bus_oe=1 and bus_out holds the addressed byte. bus_oe returns to 0 one cycle after cs_n or strb_n is released.
- R4: In data-strobe mode (style_ds=1), strb_n is the active-low data strobe. dir_pin=1 selects a read and dir_pin=0 selects a write. Reads and writes otherwise behave as in separate-strobe mode.
- R5: A write commits on the first clock edge at which either cs_n or the write strobe is seen released. It stores the last bus_in value sampled while the write was active. Releasing cs_n first and releasing the strobe first give the same result.
- R6: Pointer values 0x10 to 0x1F (upper nibble 0x1) select the internal 16-byte RAM, indexed by the lower nibble. A RAM write can be read back by the next read transfer, and it never pulses core_we.
- R7: For any other pointer value, a data write commits by pulsing core_we for exactly one cycle in the cycle after the commit edge, with core_wdata carrying the byte and core_addr the pointer. A data read returns core_rdata as sampled for that pointer.
- R8: The pointer persists across any number of data reads and writes.
- R9: While pf=1, bus_oe is 0 in that same cycle. Write attempts made while pf=1 change no RAM byte, do not move the pointer and give no core_we, and read attempts leave the bus undriven. A write that pf cuts off before its release never commits.
- R10: A read with ad_sel=1 (address phase) leaves bus_oe at 0.
- R11: In separate-strobe mode, strb_n=0 together with dir_pin=0 starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_ds | input | 1 | Strobe style strap: 0 separate strobes, 1 data strobe plus direction |
| cs_n | input | 1 | Active-low chip select |
| strb_n | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| dir_pin | input | 1 | Write strobe, active low (style 0), or direction, 1 = read (style 1) |
| ad_sel | input | 1 | 1 = address transfer, 0 = data transfer |
| pf | input | 1 | Power-fail: blocks access and releases the bus |
| bus_in | input | 8 | Byte on the shared bus toward the block |
| bus_out | output | 8 | Byte the block drives during a data read |
| bus_oe | output | 1 | Output enable of the shared bus drivers |
| core_addr | output | 8 | Current register pointer |
| core_we | output | 1 | One-cycle write pulse to a core register |
| core_wdata | output | 8 | Data byte for a core register write |
| core_rdata | input | 8 | Byte of the core register selected by core_addr |

## Verification
A read shows on the bus one cycle after the first edge that samples chip select and strobe both active, and the bus is released one cycle after the first released sample. A write commits on the edge that first sees a release. The new pointer and any RAM byte are visible from the next cycle, and core_we is high for exactly the cycle after that edge. Power-fail removes bus_oe in the same cycle it rises. The bench drives every pin on the falling edge and samples on the falling edge that follows the edge of interest, so each check lands in the cycle its result is due. The sweep covers all sixteen RAM bytes in both strobe styles, both release orders, core register traffic and power-fail cases.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   typedef struct packed {
      logic rd;
      logic wr;
   } acc_req_t;
endpackage

// File: rtl/mux_bus_strobe.sv
module mux_bus_strobe
   import mux_bus_pkg::*;
(
   input  logic     style_ds,
   input  logic     cs_n,
   input  logic     strb_n,
   input  logic     dir_pin,
   input  logic     pf,
   output acc_req_t req
);
   logic sel;
   logic sep_rd, sep_wr, ds_rd, ds_wr;

   assign sel    = ~cs_n & ~pf;
   // separate strobes: both low together is not a valid transfer (R11)
   assign sep_rd = sel & ~strb_n & dir_pin;
   assign sep_wr = sel & strb_n & ~dir_pin;
   // data strobe qualifies, direction pin chooses (R4)
   assign ds_rd  = sel & ~strb_n & dir_pin;
   assign ds_wr  = sel & ~strb_n & ~dir_pin;

   always_comb begin
      if (style_ds) begin
         req.rd = ds_rd;
         req.wr = ds_wr;
      end else begin
         req.rd = sep_rd;
         req.wr = sep_wr;
      end
   end
endmodule

// File: rtl/mux_bus_ram.sv
module mux_bus_ram #(
   parameter int DW    = 8,
   parameter int IDX_W = 4,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/mux_bus_xfer.sv
module mux_bus_xfer
   import mux_bus_pkg::*;
#(
   parameter int DW    = 8,
   parameter int IDX_W = 4,
   parameter logic [DW-IDX_W-1:0] RAM_PAGE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_req_t         req,
   input  logic             ad_sel,
   input  logic             pf,
   input  logic [DW-1:0]    bus_in,
   input  logic [DW-1:0]    ram_rdata,
   input  logic [DW-1:0]    core_rdata,
   output logic [DW-1:0]    ptr,
   output logic             ram_hit,
   output logic             ram_we,
   output logic [DW-1:0]    cap_data,
   output logic             core_we,
   output logic [DW-1:0]    core_wdata,
   output logic             oe_q,
   output logic [DW-1:0]    dout_q
);
   logic wr_q;
   logic cap_addr;
   logic commit;

   assign ram_hit = (ptr[DW-1:IDX_W] == RAM_PAGE);
   // first released sample after an active write (R5); pf aborts (R9)
   assign commit  = wr_q & ~req.wr & ~pf;
   assign ram_we  = commit & ~cap_addr & ram_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q       <= 1'b0;
         cap_addr   <= 1'b0;
         cap_data   <= '0;
         ptr        <= '0;
         core_we    <= 1'b0;
         core_wdata <= '0;
         oe_q       <= 1'b0;
         dout_q     <= '0;
      end else begin
         wr_q    <= req.wr & ~pf;
         core_we <= 1'b0;
         if (req.wr) begin
            cap_data <= bus_in;
            cap_addr <= ad_sel;
         end
         if (commit) begin
            if (cap_addr) begin
               ptr <= cap_data;
            end else if (!ram_hit) begin
               core_we    <= 1'b1;
               core_wdata <= cap_data;
            end
         end
         oe_q   <= req.rd & ~ad_sel;
         dout_q <= ram_hit ? ram_rdata : core_rdata;
      end
   end

   p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      core_we |=> !core_we);
   p_we_not_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_we |-> !ram_hit);
   p_pf_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pf |=> !core_we);
endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
   import mux_bus_pkg::*;
#(
   parameter int DW    = 8,
   parameter int IDX_W = 4,
   parameter logic [DW-IDX_W-1:0] RAM_PAGE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          style_ds,
   input  logic          cs_n,
   input  logic          strb_n,
   input  logic          dir_pin,
   input  logic          ad_sel,
   input  logic          pf,
   input  logic [DW-1:0] bus_in,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe,
   output logic [DW-1:0] core_addr,
   output logic          core_we,
   output logic [DW-1:0] core_wdata,
   input  logic [DW-1:0] core_rdata
);
   generate
      if (IDX_W < 1 || IDX_W >= DW) begin : g_bad_idx
         $error("mux_bus_if: IDX_W must lie in 1..DW-1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("mux_bus_if: DW too small");
      end
   endgenerate

   acc_req_t      req;
   logic [DW-1:0] ptr, ram_rdata, cap_data, dout_q;
   logic          ram_hit, ram_we, oe_q;

   mux_bus_strobe u_strobe (
      .style_ds (style_ds),
      .cs_n     (cs_n),
      .strb_n   (strb_n),
      .dir_pin  (dir_pin),
      .pf       (pf),
      .req      (req)
   );

   mux_bus_xfer #(.DW(DW), .IDX_W(IDX_W), .RAM_PAGE(RAM_PAGE)) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .ad_sel     (ad_sel),
      .pf         (pf),
      .bus_in     (bus_in),
      .ram_rdata  (ram_rdata),
      .core_rdata (core_rdata),
      .ptr        (ptr),
      .ram_hit    (ram_hit),
      .ram_we     (ram_we),
      .cap_data   (cap_data),
      .core_we    (core_we),
      .core_wdata (core_wdata),
      .oe_q       (oe_q),
      .dout_q     (dout_q)
   );

   mux_bus_ram #(.DW(DW), .IDX_W(IDX_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ram_we),
      .idx   (ptr[IDX_W-1:0]),
      .wdata (cap_data),
      .rdata (ram_rdata)
   );

   assign core_addr = ptr;
   assign bus_oe    = oe_q & ~pf;
   assign bus_out   = dout_q;

   p_req_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req.rd && req.wr));
   p_no_drive_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req.wr |=> !oe_q);
   p_ptr_hold_pf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pf |=> $stable(ptr));
endmodule

// File: tb/mux_bus_if_bench.sv
module mux_bus_if_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       style_ds = 1'b0, cs_n = 1'b1, strb_n = 1'b1, dir_pin = 1'b1;
   logic       ad_sel = 1'b0, pf = 1'b0;
   logic [7:0] bus_in = '0, bus_out, core_addr, core_wdata, core_rdata;
   logic       bus_oe, core_we;
   int         n_chk = 0, n_bad = 0;
   logic [7:0] rd_v;
   logic       oe_v, oe_after, we_v;
   logic [7:0] we_data, we_addr;

   always #5 clk = ~clk;
   assign core_rdata = core_addr ^ 8'h3C;

   mux_bus_if u_mux_bus_if (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one transfer; pins driven on falling edges
   task automatic xfer(input logic ds, input logic is_addr, input logic is_wr,
                       input logic [7:0] d, input logic rel_cs);
      @(negedge clk);
      style_ds = ds; ad_sel = is_addr; bus_in = d; cs_n = 1'b0;
      if (ds) begin dir_pin = ~is_wr; strb_n = 1'b0; end
      else if (is_wr) begin dir_pin = 1'b0; strb_n = 1'b1; end
      else begin dir_pin = 1'b1; strb_n = 1'b0; end
      @(negedge clk);
      rd_v = bus_out; oe_v = bus_oe;
      if (rel_cs) cs_n = 1'b1;
      else begin strb_n = 1'b1; dir_pin = 1'b1; end
      @(negedge clk);
      oe_after = bus_oe; we_v = core_we; we_data = core_wdata; we_addr = core_addr;
      cs_n = 1'b1; strb_n = 1'b1; dir_pin = 1'b1;
   endtask

   initial begin : wd
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1 oe", bus_oe, 0);
      check("R1 we", core_we, 0);
      check("R1 addr", core_addr, 0);
      rst_n = 1'b1;

      // RAM sweep, both styles, both release orders
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < 16; i++) begin
            xfer(s[0], 1, 1, 8'h10 + i[7:0], i[0]);
            check("R2 ptr", core_addr, 8'h10 + i);
            xfer(s[0], 0, 1, 8'(i * 7 + s * 3), ~i[0]);
            check("R6 no core_we", we_v, 0);
         end
         for (int i = 0; i < 16; i++) begin
            xfer(s[0], 1, 1, 8'h10 + i[7:0], 0);
            xfer(s[0], 0, 0, 8'h00, i[1]);
            check(s ? "R4 oe" : "R3 oe", oe_v, 1);
            check("R5 R6 ram data", rd_v, 8'(i * 7 + s * 3));
            check("R3 release", oe_after, 0);
         end
      end

      // core registers: write pulse and read data
      for (int a = 0; a < 4; a++) begin
         xfer(a[0], 1, 1, 8'(a * 37 + 2), 0);
         xfer(a[0], 0, 1, 8'(a + 8'hC0), a[1]);
         check("R7 we", we_v, 1);
         check("R7 wdata", we_data, 8'(a + 8'hC0));
         check("R7 addr", we_addr, 8'(a * 37 + 2));
         @(negedge clk);
         check("R7 single pulse", core_we, 0);
         xfer(a[0], 0, 0, 0, 0);
         check("R7 rdata", rd_v, 8'(a * 37 + 2) ^ 8'h3C);
         check("R8 ptr kept", core_addr, 8'(a * 37 + 2));
      end

      // address-phase read does not drive
      xfer(0, 1, 0, 0, 0);
      check("R10 oe", oe_v, 0);

      // separate style: both strobes low is nothing
      xfer(0, 1, 1, 8'h13, 0);
      xfer(0, 0, 1, 8'h55, 0);
      @(negedge clk);
      cs_n = 0; strb_n = 0; dir_pin = 0; ad_sel = 0; bus_in = 8'hEE;
      @(negedge clk);
      check("R11 oe", bus_oe, 0);
      cs_n = 1; strb_n = 1; dir_pin = 1;
      @(negedge clk);
      check("R11 we", core_we, 0);
      xfer(0, 0, 0, 0, 0);
      check("R11 ram unchanged", rd_v, 8'h55);

      // power fail
      pf = 1'b1;
      xfer(0, 0, 1, 8'hAA, 0);
      xfer(1, 1, 1, 8'h05, 0);
      check("R9 ptr", core_addr, 8'h13);
      xfer(1, 0, 0, 0, 0);
      check("R9 oe", oe_v, 0);
      pf = 1'b0;
      xfer(0, 0, 0, 0, 0);
      check("R9 ram kept", rd_v, 8'h55);
      // read active then pf rises: same-cycle release
      @(negedge clk);
      cs_n = 0; strb_n = 0; dir_pin = 1; ad_sel = 0; style_ds = 0;
      @(negedge clk);
      check("R9 pre-pf oe", bus_oe, 1);
      pf = 1'b1; #1;
      check("R9 same-cycle oe", bus_oe, 0);
      cs_n = 1; strb_n = 1;
      @(negedge clk);
      pf = 1'b0;
      // write aborted by pf
      @(negedge clk);
      cs_n = 0; dir_pin = 0; strb_n = 1; ad_sel = 0; bus_in = 8'h77;
      @(negedge clk);
      pf = 1'b1;
      @(negedge clk);
      cs_n = 1; dir_pin = 1;
      @(negedge clk);
      pf = 1'b0;
      @(negedge clk);
      xfer(0, 0, 0, 0, 0);
      check("R9 abort", rd_v, 8'h55);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule